// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard-control decisions for an in-order integer pipeline with five stages: fetch, decode, execute, memory access and write-back. Each cycle it reads register specifiers and control flags from the pipeline registers. From these it chooses, for every source operand of the execute stage, whether the ALU input comes from the register file, from the memory-stage result or from the write-back-stage result. Conditional branches are compared and resolved in decode, so the unit also chooses, for each comparator operand, whether to take the value held in the execute/memory pipeline register. The register file writes in the first half of the cycle, so a write-back-stage result needs no bypass into decode.

Fetch continues down the fall-through path. When a taken branch resolves in decode, the unit flushes the one wrong-path instruction sitting in the fetch/decode register. When a value cannot be bypassed in time, the unit holds the PC and the fetch/decode register and sends a bubble into the decode/execute register. The enclosing datapath clears every write enable and memory enable of that bubble. A load feeding the next instruction costs one stall cycle. A branch that reads an ALU result still in execute costs one stall cycle, and a branch that reads a load still in execute costs two. Instruction and data memories are separate, so the unit never stalls fetch because of a memory access.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (memory-stage result), even if the write-back stage writes the same register.
- R2: When only the write-back-stage instruction writes a nonzero register equal to an execute-stage source, the select is 2'b01. With no match the select is 2'b00 (register file).
- R3: Register 0 is never bypassed and never causes a stall, whatever the write-enable flags say.
- R4: A stage whose register-write flag is low is never a bypass source. After reset with all inputs low, every output is 0.
- R5: A load in execute whose destination equals a source that the decode instruction reads raises `pc_hold` and `idex_bubble`.
- R6: A non-load producer in execute does not stall a non-branch consumer in decode. Neither does a producer whose destination matches no source that decode uses.
- R7: A branch in decode that reads the destination of any register-writing instruction in execute stalls.
- R8: A branch in decode that reads the destination of a load in the memory stage stalls. A branch that reads a non-load result in the memory stage does not stall.
- R9: A decode comparator select (`id_fwd_a`, `id_fwd_b`) is 1 exactly when the memory-stage instruction is a register-writing non-load whose nonzero destination equals that decode source.
- R10: `ifid_flush` is 1 exactly when decode holds a branch resolved taken and no stall is raised.
- R11: `pc_hold` and `idex_bubble` are always equal. A source whose use flag is low never causes a stall.
- R12: A write-back-stage producer never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the cycle-level checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_branch_taken | input | 1 | Decode comparator resolved the branch taken |
| ex_rs | input | AW | First source register in execute |
| ex_rt | input | AW | Second source register in execute |
| ex_rd | input | AW | Destination register in execute |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register in memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination register in write-back |
| wb_reg_write | input | 1 | Write-back instruction writes a register |
| ex_fwd_a | output | 2 | Execute operand A select: 00 regfile, 01 write-back, 10 memory |
| ex_fwd_b | output | 2 | Execute operand B select, same encoding |
| id_fwd_a | output | 1 | Comparator operand A from execute/memory register |
| id_fwd_b | output | 1 | Comparator operand B from execute/memory register |
| pc_hold | output | 1 | Hold PC and fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute register |
| ifid_flush | output | 1 | Discard the wrong-path fetched instruction |

## Verification
The assertions check the rules that hold on any single cycle. They cover the equality of hold and bubble, the suppression of the flush while stalling, priority of the memory-stage bypass, the exclusion of register 0 and of loads from the decode bypass, and the stall on a load-use pair. The stall lengths of one cycle after an ALU producer and two cycles after a load are properties of a sequence of stage contents. Only the bench's cycle-by-cycle scenarios show them. The bench sweeps every combination of specifiers and flags over a four-register configuration. It compares each output against values it works out from the rules.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

  // Execute-stage operand source; encodings are visible at the ports.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Two register sources per instruction.
  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hzd_match.sv
`timescale 1ns/1ps
// Producer/consumer register match, ignoring register zero.
module hzd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);

  localparam logic [AW-1:0] REG_ZERO = '0;

  always_comb begin
    hit = wen && (dst != REG_ZERO) && (dst == src);
  end

endmodule

// File: rtl/hzd_ex_fwd.sv
`timescale 1ns/1ps
// Bypass select for one execute-stage operand.
module hzd_ex_fwd
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output fwd_sel_e      sel
);

  logic hit_mem;
  logic hit_wb;

  hzd_match #(.AW(AW)) u_mem_hit (
    .src (src),
    .dst (mem_rd),
    .wen (mem_we),
    .hit (hit_mem)
  );

  hzd_match #(.AW(AW)) u_wb_hit (
    .src (src),
    .dst (wb_rd),
    .wen (wb_we),
    .hit (hit_wb)
  );

  // The younger producer wins.
  always_comb begin
    sel = FWD_RF;
    if (hit_mem) begin
      sel = FWD_MEM;
    end else if (hit_wb) begin
      sel = FWD_WB;
    end
  end

endmodule

// File: rtl/hzd_id_ctl.sv
`timescale 1ns/1ps
// Decode-stage control: comparator bypass, stall detection, flush.
module hzd_id_ctl #(
  parameter int AW = 5,
  parameter int NS = 2
) (
  input  logic [AW-1:0] id_src [NS],
  input  logic [NS-1:0] id_use,
  input  logic          id_is_branch,
  input  logic          id_branch_taken,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_ld,
  output logic [NS-1:0] id_fwd,
  output logic          stall,
  output logic          flush
);

  logic [NS-1:0] hit_ex;
  logic [NS-1:0] hit_mem;
  logic [NS-1:0] need_ex;
  logic [NS-1:0] need_mem;

  for (genvar s = 0; s < NS; s++) begin : g_src
    hzd_match #(.AW(AW)) u_ex_hit (
      .src (id_src[s]),
      .dst (ex_rd),
      .wen (ex_we),
      .hit (hit_ex[s])
    );

    hzd_match #(.AW(AW)) u_mem_hit (
      .src (id_src[s]),
      .dst (mem_rd),
      .wen (mem_we),
      .hit (hit_mem[s])
    );

    always_comb begin
      need_ex[s]  = id_use[s] && hit_ex[s];
      need_mem[s] = id_use[s] && hit_mem[s];
      // A load's memory-stage register holds an address, not data.
      id_fwd[s]   = hit_mem[s] && !mem_ld;
    end
  end

  logic load_use;
  logic br_on_ex;
  logic br_on_mem_load;

  always_comb begin
    load_use       = ex_ld && (|need_ex);
    br_on_ex       = id_is_branch && (|need_ex);
    br_on_mem_load = id_is_branch && mem_ld && (|need_mem);
    stall          = load_use || br_on_ex || br_on_mem_load;
    // Operands are unreliable while stalling, so no redirect then.
    flush          = id_is_branch && id_branch_taken && !stall;
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_is_branch,
  input  logic          id_branch_taken,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_reg_write,
  input  logic          ex_mem_read,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_reg_write,
  input  logic          mem_mem_read,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_reg_write,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          pc_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);

  localparam int NS = NUM_SRC;

  logic [AW-1:0] ex_src [NS];
  logic [AW-1:0] id_src [NS];
  logic [NS-1:0] id_use;
  fwd_sel_e      ex_sel [NS];
  logic [NS-1:0] id_fwd;
  logic          stall;
  logic          flush;

  always_comb begin
    ex_src[0] = ex_rs;
    ex_src[1] = ex_rt;
    id_src[0] = id_rs;
    id_src[1] = id_rt;
    id_use    = {id_use_rt, id_use_rs};
  end

  for (genvar s = 0; s < NS; s++) begin : g_ex_op
    hzd_ex_fwd #(.AW(AW)) u_fwd (
      .src    (ex_src[s]),
      .mem_rd (mem_rd),
      .mem_we (mem_reg_write),
      .wb_rd  (wb_rd),
      .wb_we  (wb_reg_write),
      .sel    (ex_sel[s])
    );
  end

  hzd_id_ctl #(.AW(AW), .NS(NS)) u_id_ctl (
    .id_src          (id_src),
    .id_use          (id_use),
    .id_is_branch    (id_is_branch),
    .id_branch_taken (id_branch_taken),
    .ex_rd           (ex_rd),
    .ex_we           (ex_reg_write),
    .ex_ld           (ex_mem_read),
    .mem_rd          (mem_rd),
    .mem_we          (mem_reg_write),
    .mem_ld          (mem_mem_read),
    .id_fwd          (id_fwd),
    .stall           (stall),
    .flush           (flush)
  );

  always_comb begin
    ex_fwd_a    = ex_sel[0];
    ex_fwd_b    = ex_sel[1];
    id_fwd_a    = id_fwd[0];
    id_fwd_b    = id_fwd[1];
    pc_hold     = stall;
    idex_bubble = stall;
    ifid_flush  = flush;
  end

endmodule

// File: rtl/hzd_checker.sv
`timescale 1ns/1ps
module hzd_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs,
  input logic          id_use_rs,
  input logic          id_is_branch,
  input logic          id_branch_taken,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rd,
  input logic          ex_reg_write,
  input logic          ex_mem_read,
  input logic [AW-1:0] mem_rd,
  input logic          mem_reg_write,
  input logic          mem_mem_read,
  input logic [1:0]    ex_fwd_a,
  input logic          id_fwd_a,
  input logic          id_fwd_b,
  input logic          pc_hold,
  input logic          idex_bubble,
  input logic          ifid_flush
);

  localparam logic [AW-1:0] RZ = '0;

  AST_MEM_BYPASS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_reg_write && mem_rd != RZ && mem_rd == ex_rs) |-> (ex_fwd_a == 2'b10)); // R1

  AST_ZERO_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == RZ) |-> (ex_fwd_a == 2'b00)); // R3

  AST_LOAD_USE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && ex_reg_write && ex_rd != RZ && id_use_rs && id_rs == ex_rd)
      |-> (pc_hold && idex_bubble)); // R5

  AST_NO_LOAD_TO_COMPARATOR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mem_read |-> (!id_fwd_a && !id_fwd_b)); // R9

  AST_FLUSH_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (id_is_branch && id_branch_taken)); // R10

  AST_NO_FLUSH_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> !ifid_flush); // R10

  AST_HOLD_MATCHES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold == idex_bubble); // R11

endmodule

bind pipe_hazard_unit hzd_checker #(.AW(AW)) u_hzd_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .id_rs           (id_rs),
  .id_use_rs       (id_use_rs),
  .id_is_branch    (id_is_branch),
  .id_branch_taken (id_branch_taken),
  .ex_rs           (ex_rs),
  .ex_rd           (ex_rd),
  .ex_reg_write    (ex_reg_write),
  .ex_mem_read     (ex_mem_read),
  .mem_rd          (mem_rd),
  .mem_reg_write   (mem_reg_write),
  .mem_mem_read    (mem_mem_read),
  .ex_fwd_a        (ex_fwd_a),
  .id_fwd_a        (id_fwd_a),
  .id_fwd_b        (id_fwd_b),
  .pc_hold         (pc_hold),
  .idex_bubble     (idex_bubble),
  .ifid_flush      (ifid_flush)
);

// File: tb/pipe_hazard_unit_test.sv
`timescale 1ns/1ps
module pipe_hazard_unit_test;

  localparam int AW = 2;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_use_rs, id_use_rt, id_is_branch, id_branch_taken;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, pc_hold, idex_bubble, ifid_flush;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pipe_hazard_unit #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_is_branch(id_is_branch), .id_branch_taken(id_branch_taken),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
    .mem_rd(mem_rd), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
    .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
    .pc_hold(pc_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    id_rs = '0; id_rt = '0; id_use_rs = 0; id_use_rt = 0;
    id_is_branch = 0; id_branch_taken = 0;
    ex_rs = '0; ex_rt = '0; ex_rd = '0; ex_reg_write = 0; ex_mem_read = 0;
    mem_rd = '0; mem_reg_write = 0; mem_mem_read = 0;
    wb_rd = '0; wb_reg_write = 0;
  endtask

  function automatic int exp_ex_sel(int src, int mrd, int mwe, int wrd, int wwe);
    if (mwe != 0 && mrd != 0 && mrd == src) return 2;
    if (wwe != 0 && wrd != 0 && wrd == src) return 1;
    return 0;
  endfunction

  function automatic string ex_tag(int src, int mrd, int mwe, int wrd, int wwe);
    int e = exp_ex_sel(src, mrd, mwe, wrd, wwe);
    if (e == 2) return "R1 memory bypass";
    if (e == 1) return "R2 write-back bypass";
    if (src == 0) return "R3 zero register";
    return "R4 no bypass source";
  endfunction

  // Forwarding sweep: every execute source and producer combination.
  task automatic sweep_fwd();
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      clear_all();
      ex_rs = v[1:0]; ex_rt = v[3:2]; mem_rd = v[5:4]; wb_rd = v[7:6];
      mem_reg_write = v[8]; wb_reg_write = v[9];
      id_rs = v[7:6]; id_rt = v[7:6]; id_use_rs = 1; id_use_rt = 1; id_is_branch = 1;
      #1;
      chk(ex_tag(v & 3, (v >> 4) & 3, v[8], (v >> 6) & 3, v[9]), int'(ex_fwd_a),
          exp_ex_sel(v & 3, (v >> 4) & 3, v[8], (v >> 6) & 3, v[9]));
      chk(ex_tag((v >> 2) & 3, (v >> 4) & 3, v[8], (v >> 6) & 3, v[9]), int'(ex_fwd_b),
          exp_ex_sel((v >> 2) & 3, (v >> 4) & 3, v[8], (v >> 6) & 3, v[9]));
      chk("R12 write-back producer stall", int'(pc_hold), 0);
      chk("R9 comparator select", int'(id_fwd_a),
          (v[8] && ((v >> 4) & 3) != 0 && ((v >> 4) & 3) == ((v >> 6) & 3)) ? 1 : 0);
    end
  endtask

  // Stall sweep: decode sources, flags and execute/memory producers.
  task automatic sweep_stall();
    for (int v = 0; v < 65536; v++) begin
      int rs, rt, erd, mrd;
      bit urs, urt, br, tk, ewe, eld, mwe, mld;
      bit dex, dmem, lu, b_ex, b_ml, st;
      rs = v & 3; rt = (v >> 2) & 3; erd = (v >> 4) & 3; mrd = (v >> 6) & 3;
      urs = v[8]; urt = v[9]; br = v[10]; tk = v[11];
      ewe = v[12]; eld = v[13]; mwe = v[14]; mld = v[15];
      if ((eld && !ewe) || (mld && !mwe)) continue;
      @(negedge clk);
      clear_all();
      id_rs = rs[AW-1:0]; id_rt = rt[AW-1:0]; ex_rd = erd[AW-1:0]; mem_rd = mrd[AW-1:0];
      id_use_rs = urs; id_use_rt = urt; id_is_branch = br; id_branch_taken = tk;
      ex_reg_write = ewe; ex_mem_read = eld; mem_reg_write = mwe; mem_mem_read = mld;
      #1;
      dex  = ewe && erd != 0 && ((urs && erd == rs) || (urt && erd == rt));
      dmem = mwe && mrd != 0 && ((urs && mrd == rs) || (urt && mrd == rt));
      lu   = eld && dex;
      b_ex = br && dex;
      b_ml = br && mld && dmem;
      st   = lu || b_ex || b_ml;
      if (lu)        chk("R5 load-use stall", int'(pc_hold), 1);
      else if (b_ex) chk("R7 branch on execute result", int'(pc_hold), 1);
      else if (b_ml) chk("R8 branch on memory-stage load", int'(pc_hold), 1);
      else           chk("R6/R8/R11 no stall", int'(pc_hold), 0);
      chk("R11 bubble equals hold", int'(idex_bubble), int'(st));
      chk("R10 flush", int'(ifid_flush), (br && tk && !st) ? 1 : 0);
      chk("R9 comparator select a", int'(id_fwd_a),
          (mwe && !mld && mrd != 0 && mrd == rs) ? 1 : 0);
      chk("R9 comparator select b", int'(id_fwd_b),
          (mwe && !mld && mrd != 0 && mrd == rt) ? 1 : 0);
    end
  endtask

  // Cycle-by-cycle sequences with stage contents advancing.
  task automatic seq_load_branch();
    // Cycle 1: load r2 in execute, branch on r2 in decode.
    @(negedge clk); clear_all();
    id_rs = 2'd2; id_use_rs = 1; id_is_branch = 1; id_branch_taken = 1;
    ex_rd = 2'd2; ex_reg_write = 1; ex_mem_read = 1;
    #1; chk("R8 load-branch stall cycle 1", int'(pc_hold), 1);
    chk("R10 no flush while stalled", int'(ifid_flush), 0);
    // Cycle 2: bubble in execute, load in memory stage.
    @(negedge clk);
    ex_rd = '0; ex_reg_write = 0; ex_mem_read = 0;
    mem_rd = 2'd2; mem_reg_write = 1; mem_mem_read = 1;
    #1; chk("R8 load-branch stall cycle 2", int'(pc_hold), 1);
    chk("R9 load not bypassed to comparator", int'(id_fwd_a), 0);
    // Cycle 3: load in write-back, register file covers it.
    @(negedge clk);
    mem_rd = '0; mem_reg_write = 0; mem_mem_read = 0;
    wb_rd = 2'd2; wb_reg_write = 1;
    #1; chk("R12 load in write-back no stall", int'(pc_hold), 0);
    chk("R10 taken branch flushes", int'(ifid_flush), 1);
  endtask

  task automatic seq_alu_branch();
    @(negedge clk); clear_all();
    id_rs = 2'd1; id_rt = 2'd3; id_use_rs = 1; id_use_rt = 1; id_is_branch = 1;
    ex_rd = 2'd3; ex_reg_write = 1;
    #1; chk("R7 ALU-branch stall cycle 1", int'(pc_hold), 1);
    @(negedge clk);
    ex_rd = '0; ex_reg_write = 0;
    mem_rd = 2'd3; mem_reg_write = 1;
    #1; chk("R7 ALU-branch resumes cycle 2", int'(pc_hold), 0);
    chk("R9 comparator b from memory stage", int'(id_fwd_b), 1);
    chk("R10 not-taken branch no flush", int'(ifid_flush), 0);
  endtask

  initial begin
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R4 reset ex_fwd_a", int'(ex_fwd_a), 0);
    chk("R4 reset ex_fwd_b", int'(ex_fwd_b), 0);
    chk("R4 reset hold", int'(pc_hold), 0);
    chk("R4 reset flush", int'(ifid_flush), 0);
    seq_load_branch();
    seq_alu_branch();
    sweep_fwd();
    sweep_stall();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (199000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule